// File: doc/BRIEF.md
# Spare-Column Row Shift Remapper

This block translates logical cell positions in a small array of logic cells into physical positions. The array has a fixed number of rows. Each row holds the logical columns plus one extra column at its right edge that is kept in reserve. A fault map is written into the block's own storage, one entry per row. An entry is a valid flag and the physical column index of a bad cell. All remapping is done by logic inside the block.

When a row carries a fault, every logical cell whose column is at or beyond the bad position moves one place to the right, into the reserve column. Cells to the left of the fault keep their place. The block also drives one shift select per physical cell. Each select tells that cell's input multiplexer to take the signal meant for its left neighbour, so the bad cell is bypassed.

Each row can absorb one fault. A second fault written to a row that already has one is refused, and a sticky error flag is raised.

Top module: `spare_col_remapper`

## Requirements
- R1: A synchronous active-low reset clears every row's valid flag and the error flag, so after reset every logical column maps to the same physical column and all shift selects are 0.
- R2: In a row with no recorded fault, logical column c maps to physical column c and the reserve column is unused.
- R3: In a row whose fault sits at physical column f, logical column c maps to c+1 when c >= f and to c when c < f.
- R4: The lookup is combinational in the lookup row and column. A fault-map write changes the mapping only after the next rising clock edge.
- R5: A write to a row that already holds a fault raises the error flag and leaves that row's stored entry, and so its mapping, unchanged.
- R6: The error flag stays at 1 until the next reset, whatever writes follow.
- R7: A write whose column index exceeds the number of logical columns, or whose row index is not below the row count, is refused. It raises the error flag and changes no entry.
- R8: Shift select bit r*(COLS+1)+p is 1 exactly when row r holds a fault at column f and p > f. Position p = 0 is never selected.
- R9: A fault recorded in the reserve column (f = COLS) moves no logical cell, and the row's shift selects all stay 0.
- R10: Rows are remapped independently; a write to one row never alters another row's mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Fault-map write strobe |
| wr_row | input | RW | Row of the fault being recorded |
| wr_col | input | CW | Physical column of the fault being recorded |
| lk_row | input | RW | Lookup row |
| lk_col | input | CW | Lookup logical column |
| lk_phys | output | CW | Physical column for the looked-up cell |
| shift_sel | output | ROWS*(COLS+1) | Per-cell bypass select, row-major |
| err_o | output | 1 | Sticky refused-write flag |

## Verification
On every cycle, the assertions check four things:
- A looked-up position never moves by more than one column.
- Any cell that moves lands on a physical cell whose shift select is raised.
- A write to a faulted row raises the error flag and leaves that row's selects frozen.
- The error flag holds once set, and a reset clears it.

Several behaviours need the bench's scenarios to show them:
- Exactly where the shift boundary falls.
- The one-cycle delay between a write and its effect.
- Refusal of out-of-range writes.
- The case of a fault in the reserve column.
- The isolation between rows.

// File: rtl/spare_remap_pkg.sv
// Package: shared types for the spare-column remapper.
// Assumes nothing beyond IEEE 1800-2017 packed enums.
package spare_remap_pkg;

    // Outcome of a fault-map write request.
    typedef enum logic [1:0] {
        WR_ACCEPT = 2'd0,
        WR_DUP    = 2'd1,
        WR_RANGE  = 2'd2
    } wr_verdict_e;

endpackage

// File: rtl/spare_remap_fault_mem.sv
// Fault-map storage: one valid flag and one fault column per row.
// Judges each write, keeps the sticky error flag.
// Assumes wr_* is sampled only while wr_en is high.
module spare_remap_fault_mem
    import spare_remap_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RW-1:0]        wr_row,
    input  logic [CW-1:0]        wr_col,
    output logic [ROWS-1:0]      valid_o,
    output logic [ROWS*CW-1:0]   fcol_o,
    output logic                 err_o
);

    logic [ROWS-1:0]    valid_q;
    logic [ROWS*CW-1:0] fcol_q;
    logic               err_q;
    wr_verdict_e        verdict;

    // Classify the pending write against range limits and current contents.
    always_comb begin
        verdict = WR_ACCEPT;
        if (int'(wr_col) > COLS || int'(wr_row) >= ROWS)
            verdict = WR_RANGE;
        else if (valid_q[wr_row])
            verdict = WR_DUP;
    end

    // Store accepted faults; flag refused writes until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            fcol_q  <= '0;
            err_q   <= 1'b0;
        end else if (wr_en) begin
            if (verdict == WR_ACCEPT) begin
                valid_q[wr_row]               <= 1'b1;
                fcol_q[wr_row*CW +: CW]       <= wr_col;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign fcol_o  = fcol_q;
    assign err_o   = err_q;

endmodule

// File: rtl/spare_remap_col_xlate.sv
// Combinational logical-to-physical column translation for one lookup.
// Assumes lk_row < ROWS and lk_col < COLS.
module spare_remap_col_xlate #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input  logic [ROWS-1:0]    valid_i,
    input  logic [ROWS*CW-1:0] fcol_i,
    input  logic [RW-1:0]      lk_row,
    input  logic [CW-1:0]      lk_col,
    output logic [CW-1:0]      lk_phys
);

    logic [CW-1:0] row_fcol;
    logic          row_valid;

    // Pick the addressed row's entry and shift at or past its fault.
    always_comb begin
        row_fcol  = fcol_i[lk_row*CW +: CW];
        row_valid = valid_i[lk_row];
        if (row_valid && (lk_col >= row_fcol))
            lk_phys = lk_col + CW'(1);
        else
            lk_phys = lk_col;
    end

endmodule

// File: rtl/spare_remap_bypass_gen.sv
// Per-cell bypass selects: a physical cell right of its row's fault
// takes its left neighbour's signal. Assumes ROWS*(COLS+1) fits easily.
module spare_remap_bypass_gen #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int CW   = 3
) (
    input  logic [ROWS-1:0]          valid_i,
    input  logic [ROWS*CW-1:0]       fcol_i,
    output logic [ROWS*(COLS+1)-1:0] shift_sel
);

    localparam int PCOLS = COLS + 1;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar p = 0; p < PCOLS; p++) begin : g_cell
            // Select the shifted path for cells beyond the fault.
            assign shift_sel[r*PCOLS + p] =
                valid_i[r] && (CW'(p) > fcol_i[r*CW +: CW]);
        end
    end

endmodule

// File: rtl/spare_col_remapper.sv
// Top: fault-map storage, lookup translation and bypass select generation
// for an array with one reserve column. Assumes lookups stay in range.
module spare_col_remapper #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    localparam int PCOLS = COLS + 1,
    localparam int CW    = $clog2(COLS + 1),
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RW-1:0]          wr_row,
    input  logic [CW-1:0]          wr_col,
    input  logic [RW-1:0]          lk_row,
    input  logic [CW-1:0]          lk_col,
    output logic [CW-1:0]          lk_phys,
    output logic [ROWS*PCOLS-1:0]  shift_sel,
    output logic                   err_o
);

    logic [ROWS-1:0]    valid_w;
    logic [ROWS*CW-1:0] fcol_w;

    spare_remap_fault_mem #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .valid_o (valid_w),
        .fcol_o  (fcol_w),
        .err_o   (err_o)
    );

    spare_remap_col_xlate #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) xlate_i (
        .valid_i (valid_w),
        .fcol_i  (fcol_w),
        .lk_row  (lk_row),
        .lk_col  (lk_col),
        .lk_phys (lk_phys)
    );

    spare_remap_bypass_gen #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) byp_i (
        .valid_i   (valid_w),
        .fcol_i    (fcol_w),
        .shift_sel (shift_sel)
    );

endmodule

// File: rtl/spare_col_remapper_chk.sv
// Checker bound to the top: relates lookup, selects and error flag.
module spare_col_remapper_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [RW-1:0]          wr_row,
    input logic [RW-1:0]          lk_row,
    input logic [CW-1:0]          lk_col,
    input logic [CW-1:0]          lk_phys,
    input logic [ROWS*(COLS+1)-1:0] shift_sel,
    input logic                   err_o
);

    localparam int PCOLS = COLS + 1;

    logic [PCOLS-1:0] wr_row_sel;
    logic             moved_hit;

    // Gather the write row's selects and the select under a moved lookup.
    always_comb begin
        wr_row_sel = shift_sel[int'(wr_row)*PCOLS +: PCOLS];
        moved_hit  = shift_sel[int'(lk_row)*PCOLS + int'(lk_phys)];
    end

    assert_reset_clears_err_R1: assert property (@(posedge clk)
        !rst_n |=> !err_o);

    assert_shift_at_most_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_col) < COLS) |->
        (lk_phys == lk_col || lk_phys == lk_col + CW'(1)));

    assert_moved_cell_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_col) < COLS && int'(lk_row) < ROWS && lk_phys != lk_col) |-> moved_hit);

    assert_dup_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_row) < ROWS && (|wr_row_sel)) |=> err_o);

    assert_dup_write_keeps_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_row) < ROWS && (|wr_row_sel)) |=> $stable(shift_sel));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind spare_col_remapper spare_col_remapper_chk #(
    .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .lk_row    (lk_row),
    .lk_col    (lk_col),
    .lk_phys   (lk_phys),
    .shift_sel (shift_sel),
    .err_o     (err_o)
);

// File: tb/spare_col_remapper_tb_top.sv
module spare_col_remapper_tb_top;

    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int PCOLS = COLS + 1;
    localparam int CW    = $clog2(COLS + 1);
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [RW-1:0]         wr_row = '0;
    logic [CW-1:0]         wr_col = '0;
    logic [RW-1:0]         lk_row = '0;
    logic [CW-1:0]         lk_col = '0;
    logic [CW-1:0]         lk_phys;
    logic [ROWS*PCOLS-1:0] shift_sel;
    logic                  err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_valid [ROWS];
    int m_fcol  [ROWS];
    bit m_err;

    always #5 clk = ~clk;

    spare_col_remapper #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .lk_row(lk_row), .lk_col(lk_col), .lk_phys(lk_phys),
        .shift_sel(shift_sel), .err_o(err_o)
    );

    // Expected physical column from the requirements.
    function automatic int exp_phys(int r, int c);
        return (m_valid[r] && c >= m_fcol[r]) ? c + 1 : c;
    endfunction

    // Expected select vector from the requirements.
    function automatic logic [ROWS*PCOLS-1:0] exp_sel();
        logic [ROWS*PCOLS-1:0] v = '0;
        for (int r = 0; r < ROWS; r++)
            for (int p = 0; p < PCOLS; p++)
                v[r*PCOLS+p] = m_valid[r] && (p > m_fcol[r]);
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < ROWS; r++) begin
            m_valid[r] = 1'b0;
            m_fcol[r]  = 0;
        end
        m_err = 1'b0;
    endtask

    // Full sweep of every lookup, every select and the flag.
    task automatic check_all(string ctx);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                lk_row = RW'(r);
                lk_col = CW'(c);
                #1;
                if (m_valid[r] && m_fcol[r] == COLS)
                    chk({ctx, " R9 phys"}, int'(lk_phys), exp_phys(r, c));
                else if (m_valid[r])
                    chk({ctx, " R3 phys"}, int'(lk_phys), exp_phys(r, c));
                else
                    chk({ctx, " R2 phys"}, int'(lk_phys), exp_phys(r, c));
            end
        end
        n_cmp++;
        if (shift_sel !== exp_sel()) begin
            n_bad++;
            $display("FAIL %s R8 sel: actual %h expected %h", ctx, shift_sel, exp_sel());
        end
        chk({ctx, " R6 err"}, int'(err_o), int'(m_err));
    endtask

    // One write cycle; model updated after the edge.
    task automatic do_write(int r, int c);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_row = RW'(r);
        wr_col = CW'(c);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (c > COLS || r >= ROWS) m_err = 1'b1;
        else if (m_valid[r]) m_err = 1'b1;
        else begin
            m_valid[r] = 1'b1;
            m_fcol[r]  = c;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        model_reset();
        do_reset();
        check_all("R1 reset");

        // R4: a write is not visible before the edge, visible after.
        @(negedge clk);
        wr_en = 1'b1; wr_row = 0; wr_col = 1;
        lk_row = 0; lk_col = 2;
        #1;
        chk("R4 before edge", int'(lk_phys), 2);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        m_valid[0] = 1'b1; m_fcol[0] = 1;
        chk("R4 after edge", int'(lk_phys), 3);
        lk_col = 0;
        #1;
        chk("R3 left of fault", int'(lk_phys), 0);
        check_all("R10 one row");

        // R5: second fault refused.
        do_write(0, 3);
        chk("R5 err set", int'(err_o), 1);
        lk_row = 0; lk_col = 2;
        #1;
        chk("R5 entry kept", int'(lk_phys), 3);
        check_all("R5");

        // R7: out-of-range column on a clean row.
        do_reset();
        do_write(1, 7);
        chk("R7 err set", int'(err_o), 1);
        lk_row = 1; lk_col = 3;
        #1;
        chk("R7 row untouched", int'(lk_phys), 3);
        check_all("R7");

        // R6: a later accepted write keeps the flag.
        do_write(2, COLS);
        chk("R6 sticky", int'(err_o), 1);
        check_all("R9 spare fault");
        do_write(3, 0);
        check_all("R10 col0");

        // Random phase.
        for (int k = 0; k < 60; k++) begin
            if (k % 15 == 0) do_reset();
            do_write(int'($urandom_range(ROWS - 1)), int'($urandom_range(7)));
            check_all("R10 rand");
        end

        do_reset();
        check_all("R1 final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule